// File: doc/BRIEF.md
# Receive Descriptor Chain Engine

This block moves incoming frames into host memory by walking a singly linked chain of receive descriptors. Software first loads the address of the first descriptor, then issues an enable command. The engine reads the descriptor and checks its ownership bit. It writes the frame bytes into the descriptor's buffer and writes back a completion status. It then follows the descriptor's link to the next entry, or stops when the link is null.

Every descriptor holds, in order, a link pointer, a buffer pointer, a command/status word and an extended status word. In compact mode the two pointers are one 32-bit word each. In wide mode each pointer is two words, low word first. Wide mode therefore moves the command/status word from byte offset 8 to byte offset 16. All memory traffic goes through one request port that carries one word or one byte per transfer, and only one transfer is outstanding at a time. Completion and stop conditions are reported as single-cycle interrupt-cause pulses.

Top module: `rxd_engine`

## Requirements
- R1: A `cmdEnable` pulse while the engine is idle starts a descriptor read at `descPtr`. If `cmdDisable` is high in the same cycle, the disable wins, no read starts and the engine stays stopped.
- R2: A descriptor read is a series of 32-bit word reads at consecutive addresses from the descriptor base: 4 words in compact mode and 6 in wide mode. Every descriptor address driven on `memAddr` is the pointer ANDed with 0x3FFFFFFF.
- R3: If bit 31 (ownership) of the fetched command/status word is already set, the engine pulses `irqRxIdle`, returns to idle and makes no memory write and no `irqRxOk`.
- R4: If bit 31 is clear, the frame bytes are written one byte write each to consecutive addresses, starting at the low 32 bits of the buffer pointer. At most cmdsts[15:0] bytes are written. Bytes beyond that budget are still accepted but are not written.
- R5: The status written back is the fetched command/status word with bit 31 set, bit 30 (more) cleared and bit 27 (ok) set. Bits 15:0 are replaced by `frmLen` as sampled with the last byte. Bit 29 (intr) keeps its value.
- R6: The writeback is exactly two word writes: the new status at base+8 (compact) or base+16 (wide), then the unchanged extended status word at the next word address.
- R7: After the writeback, `irqRxOk` pulses once, and `irqRxDesc` pulses in the same cycle if bit 29 of the status is set.
- R8: After a completion with a zero link, `irqRxIdle` pulses, `descDone` goes high and the engine idles. With a nonzero link, `descPtr` takes the link's low 32 bits, `descDone` clears and the next descriptor is read at once.
- R9: If a disable command has arrived by the time a descriptor completes, the engine goes idle after `irqRxOk` without reading the next descriptor and without `irqRxIdle`.
- R10: While `memReq` is high and `memDone` has not arrived, `memReq`, `memAddr` and `memWdata` hold their values.
- R11: The compact or wide mode is sampled from `mode64` when the enable command starts the engine. It is held for the whole chain walk, even if `mode64` changes.
- R12: After reset, `memReq`, `frmReady`, `descDone` and all interrupt pulses are low and `descPtr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdEnable | input | 1 | Receive enable command pulse |
| cmdDisable | input | 1 | Receive disable command pulse (wins over enable) |
| mode64 | input | 1 | Wide descriptor pointer mode select |
| ptrWrEn | input | 1 | Load strobe for the descriptor pointer |
| ptrWrData | input | 32 | Value loaded into the descriptor pointer |
| descPtr | output | 32 | Current descriptor pointer |
| descDone | output | 1 | Chain ended on a null link |
| memReq | output | 1 | Memory transfer request, held until done |
| memWrite | output | 1 | Transfer is a write |
| memByte | output | 1 | Transfer is a single byte (data) rather than a word |
| memAddr | output | 32 | Byte address of the transfer |
| memWdata | output | 32 | Write data (byte writes use bits 7:0) |
| memRdata | input | 32 | Read data, valid with memDone |
| memDone | input | 1 | One-cycle completion of the pending transfer |
| frmValid | input | 1 | Frame byte available |
| frmByte | input | 8 | Frame byte |
| frmLast | input | 1 | Marks the last byte of a frame |
| frmLen | input | 16 | Frame length, sampled with the last byte |
| frmReady | output | 1 | Engine accepts a frame byte this cycle |
| irqRxOk | output | 1 | Pulse: a descriptor completed |
| irqRxDesc | output | 1 | Pulse: the completed descriptor requested an interrupt |
| irqRxIdle | output | 1 | Pulse: receive stopped on an owned descriptor or a null link |

## Verification
The main path is driven by a table of single-descriptor chains. The rows vary the descriptor mode, the byte budget against the frame length (under, exact and over), the incoming more and intr bits, and pre-set ownership. Under budget against over budget separates correct clipping from writing past the buffer. Compact against wide rows separate the two descriptor layouts through the read count and the writeback offset. One row flips `mode64` just after the kick to show that the mode is latched. Directed runs cover a two-descriptor chain with a masked link, a disable that arrives mid-frame, and a combined enable and disable.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  localparam int WORD_W   = 32;
  localparam int LEN_W    = 16;
  localparam int OWN_BIT  = 31;
  localparam int MORE_BIT = 30;
  localparam int INTR_BIT = 29;
  localparam int OK_BIT   = 27;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_RECV,
    ST_WRITE,
    ST_STATUS,
    ST_WB,
    ST_POST,
    ST_ADV
  } rxdStateT;

  typedef enum logic [1:0] {
    SEL_FETCH,
    SEL_DATA,
    SEL_WB
  } addrSelT;

  // strobes from control to datapath
  typedef struct packed {
    logic kick;       // start of a chain walk: latch mode, reset word index
    logic capWord;    // capture memRdata into the cached descriptor
    logic startData;  // load fragment pointer and byte budget
    logic takeByte;   // accept one frame byte
    logic byteDone;   // a byte write completed
    logic setStatus;  // build completion status
    logic wbStep;     // a writeback word completed
    logic follow;     // load link into descriptor pointer
    logic setDone;    // chain ended on null link
    logic clrDone;    // chain continues
  } ctrlStrobeT;

endpackage

// File: rtl/rxd_path.sv
module rxd_path
  import rxd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ADDR_KEEP = 30
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strb,
  input  addrSelT            addrSel,
  input  logic               mode64,
  input  logic               ptrWrEn,
  input  logic [ADDR_W-1:0]  ptrWrData,
  input  logic [WORD_W-1:0]  memRdata,
  input  logic [7:0]         frmByte,
  input  logic               frmLast,
  input  logic [LEN_W-1:0]   frmLen,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [WORD_W-1:0]  memWdata,
  output logic [ADDR_W-1:0]  descPtr,
  output logic               descDone,
  output logic               fetchLast,
  output logic               wbLast,
  output logic               ownSet,
  output logic               intrSet,
  output logic               linkZero,
  output logic               inBudget,
  output logic               lastSeen
);

  localparam int IDX_W     = 3;
  localparam int LINK_W    = 2 * WORD_W;
  localparam int OFF_NARROW = 8;
  localparam int OFF_WIDE   = 16;

  logic [ADDR_W-1:0] keepMask;

  generate
    for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
      if (b < ADDR_KEEP) begin : g_keep
        assign keepMask[b] = 1'b1;
      end else begin : g_drop
        assign keepMask[b] = 1'b0;
      end
    end
  endgenerate

  logic              modeWide;
  logic [IDX_W-1:0]  wIdx;
  logic [LINK_W-1:0] linkQ;
  logic [WORD_W-1:0] bufQ;
  logic [WORD_W-1:0] cmdQ;
  logic [WORD_W-1:0] extQ;
  logic [ADDR_W-1:0] fragPtr;
  logic [LEN_W-1:0]  budget;
  logic [7:0]        byteQ;
  logic              lastQ;
  logic [LEN_W-1:0]  lenQ;
  logic [IDX_W-1:0]  slot;

  // normalise the word index to the wide layout
  always_comb begin
    if (modeWide) slot = wIdx;
    else if (wIdx < 3'd2) slot = {wIdx[1:0], 1'b0};
    else slot = wIdx + 3'd2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descPtr  <= '0;
      descDone <= 1'b0;
      modeWide <= 1'b0;
      wIdx     <= '0;
      linkQ    <= '0;
      bufQ     <= '0;
      cmdQ     <= '0;
      extQ     <= '0;
      fragPtr  <= '0;
      budget   <= '0;
      byteQ    <= '0;
      lastQ    <= 1'b0;
      lenQ     <= '0;
    end else begin
      if (strb.follow) descPtr <= linkQ[ADDR_W-1:0];
      else if (ptrWrEn) descPtr <= ptrWrData;

      if (strb.setDone) descDone <= 1'b1;
      else if (strb.clrDone) descDone <= 1'b0;

      if (strb.kick) modeWide <= mode64;

      if (strb.kick || strb.follow) begin
        wIdx  <= '0;
        linkQ <= '0;
        bufQ  <= '0;
      end else if (strb.capWord) begin
        wIdx <= wIdx + 3'd1;
        case (slot)
          3'd0: linkQ[WORD_W-1:0]      <= memRdata;
          3'd1: linkQ[LINK_W-1:WORD_W] <= memRdata;
          3'd2: bufQ                   <= memRdata;
          3'd4: cmdQ                   <= memRdata;
          3'd5: extQ                   <= memRdata;
          default: ;
        endcase
      end else if (strb.setStatus) begin
        wIdx <= '0;
      end else if (strb.wbStep) begin
        wIdx <= wIdx + 3'd1;
      end

      if (strb.startData) begin
        fragPtr <= bufQ[ADDR_W-1:0];
        budget  <= cmdQ[LEN_W-1:0];
        lastQ   <= 1'b0;
      end

      if (strb.takeByte) begin
        byteQ <= frmByte;
        lastQ <= frmLast;
        if (frmLast) lenQ <= frmLen;
      end

      if (strb.byteDone) begin
        fragPtr <= fragPtr + 1'b1;
        budget  <= budget - 1'b1;
      end

      if (strb.setStatus) begin
        cmdQ[OWN_BIT]          <= 1'b1;
        cmdQ[MORE_BIT]         <= 1'b0;
        cmdQ[OK_BIT]           <= 1'b1;
        cmdQ[LEN_W-1:0]        <= lenQ;
      end
    end
  end

  logic [ADDR_W-1:0] wordOff;
  logic [ADDR_W-1:0] statOff;

  assign wordOff = ADDR_W'({wIdx, 2'b00});
  assign statOff = modeWide ? ADDR_W'(OFF_WIDE) : ADDR_W'(OFF_NARROW);

  always_comb begin
    unique case (addrSel)
      SEL_DATA: begin
        memAddr  = fragPtr;
        memWdata = {{(WORD_W-8){1'b0}}, byteQ};
      end
      SEL_WB: begin
        memAddr  = (descPtr + statOff + wordOff) & keepMask;
        memWdata = wIdx[0] ? extQ : cmdQ;
      end
      default: begin
        memAddr  = (descPtr + wordOff) & keepMask;
        memWdata = '0;
      end
    endcase
  end

  assign fetchLast = (wIdx == (modeWide ? 3'd5 : 3'd3));
  assign wbLast    = wIdx[0];
  assign ownSet    = cmdQ[OWN_BIT];
  assign intrSet   = cmdQ[INTR_BIT];
  assign linkZero  = (linkQ == '0);
  assign inBudget  = (budget != '0);
  assign lastSeen  = lastQ;

  // a byte write may only complete while budget remains
  assert_budget_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.byteDone |-> budget != '0);

endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdEnable,
  input  logic       cmdDisable,
  input  logic       memDone,
  input  logic       frmValid,
  input  logic       frmLast,
  input  logic       fetchLast,
  input  logic       wbLast,
  input  logic       ownSet,
  input  logic       intrSet,
  input  logic       linkZero,
  input  logic       inBudget,
  input  logic       lastSeen,
  output ctrlStrobeT strb,
  output addrSelT    addrSel,
  output logic       memReq,
  output logic       memWrite,
  output logic       memByte,
  output logic       frmReady,
  output logic       irqRxOk,
  output logic       irqRxDesc,
  output logic       irqRxIdle
);

  rxdStateT state;
  rxdStateT nextState;
  logic     rxOn;
  logic     enFire;

  assign enFire = cmdEnable && !cmdDisable;

  always_comb begin
    nextState = state;
    strb      = '0;
    addrSel   = SEL_FETCH;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    memByte   = 1'b0;
    frmReady  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (enFire) begin
          strb.kick = 1'b1;
          nextState = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memDone) begin
          strb.capWord = 1'b1;
          if (fetchLast) nextState = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (ownSet) begin
          nextState = ST_IDLE;
        end else begin
          strb.startData = 1'b1;
          nextState = ST_RECV;
        end
      end
      ST_RECV: begin
        frmReady = 1'b1;
        if (frmValid) begin
          strb.takeByte = 1'b1;
          if (inBudget) nextState = ST_WRITE;
          else if (frmLast) nextState = ST_STATUS;
        end
      end
      ST_WRITE: begin
        addrSel  = SEL_DATA;
        memReq   = 1'b1;
        memWrite = 1'b1;
        memByte  = 1'b1;
        if (memDone) begin
          strb.byteDone = 1'b1;
          nextState = lastSeen ? ST_STATUS : ST_RECV;
        end
      end
      ST_STATUS: begin
        strb.setStatus = 1'b1;
        nextState = ST_WB;
      end
      ST_WB: begin
        addrSel  = SEL_WB;
        memReq   = 1'b1;
        memWrite = 1'b1;
        if (memDone) begin
          strb.wbStep = 1'b1;
          if (wbLast) nextState = ST_POST;
        end
      end
      ST_POST: begin
        nextState = rxOn ? ST_ADV : ST_IDLE;
      end
      ST_ADV: begin
        if (linkZero) begin
          strb.setDone = 1'b1;
          nextState = ST_IDLE;
        end else begin
          strb.follow  = 1'b1;
          strb.clrDone = 1'b1;
          nextState = ST_FETCH;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rxOn      <= 1'b0;
      irqRxOk   <= 1'b0;
      irqRxDesc <= 1'b0;
      irqRxIdle <= 1'b0;
    end else begin
      state <= nextState;
      if (cmdDisable) rxOn <= 1'b0;
      else if (cmdEnable) rxOn <= 1'b1;
      irqRxOk   <= (state == ST_POST);
      irqRxDesc <= (state == ST_POST) && intrSet;
      irqRxIdle <= ((state == ST_CHECK) && ownSet) ||
                   ((state == ST_ADV) && linkZero);
    end
  end

endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
  import rxd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ADDR_KEEP = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdEnable,
  input  logic              cmdDisable,
  input  logic              mode64,
  input  logic              ptrWrEn,
  input  logic [ADDR_W-1:0] ptrWrData,
  output logic [ADDR_W-1:0] descPtr,
  output logic              descDone,
  output logic              memReq,
  output logic              memWrite,
  output logic              memByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memDone,
  input  logic              frmValid,
  input  logic [7:0]        frmByte,
  input  logic              frmLast,
  input  logic [15:0]       frmLen,
  output logic              frmReady,
  output logic              irqRxOk,
  output logic              irqRxDesc,
  output logic              irqRxIdle
);

  ctrlStrobeT strb;
  addrSelT    addrSel;
  logic fetchLast, wbLast, ownSet, intrSet, linkZero, inBudget, lastSeen;

  rxd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable),
    .memDone(memDone), .frmValid(frmValid), .frmLast(frmLast),
    .fetchLast(fetchLast), .wbLast(wbLast), .ownSet(ownSet),
    .intrSet(intrSet), .linkZero(linkZero), .inBudget(inBudget),
    .lastSeen(lastSeen),
    .strb(strb), .addrSel(addrSel),
    .memReq(memReq), .memWrite(memWrite), .memByte(memByte),
    .frmReady(frmReady),
    .irqRxOk(irqRxOk), .irqRxDesc(irqRxDesc), .irqRxIdle(irqRxIdle)
  );

  rxd_path #(.ADDR_W(ADDR_W), .ADDR_KEEP(ADDR_KEEP)) u_path (
    .clk(clk), .rstN(rstN),
    .strb(strb), .addrSel(addrSel), .mode64(mode64),
    .ptrWrEn(ptrWrEn), .ptrWrData(ptrWrData),
    .memRdata(memRdata), .frmByte(frmByte), .frmLast(frmLast),
    .frmLen(frmLen),
    .memAddr(memAddr), .memWdata(memWdata),
    .descPtr(descPtr), .descDone(descDone),
    .fetchLast(fetchLast), .wbLast(wbLast), .ownSet(ownSet),
    .intrSet(intrSet), .linkZero(linkZero), .inBudget(inBudget),
    .lastSeen(lastSeen)
  );

  // a pending transfer keeps its request, address and data until done
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memDone |=> memReq && $stable(memAddr) && $stable(memWdata));

  // word transfers only touch descriptors, which are always masked
  assert_desc_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memByte |-> memAddr[ADDR_W-1:ADDR_KEEP] == '0);

  // completion and stop causes never coincide
  assert_irq_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqRxOk, irqRxIdle}));

  // the chain-end flag only rises together with the idle cause
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(descDone) |-> irqRxIdle);

endmodule

// File: tb/tb_rxd_engine.sv
`timescale 1ns/1ps
module tb_rxd_engine;

  localparam int LAT = 2;
  localparam logic [31:0] MASK = 32'h3FFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdEnable = 1'b0, cmdDisable = 1'b0, mode64 = 1'b0;
  logic ptrWrEn = 1'b0;
  logic [31:0] ptrWrData = '0;
  logic [31:0] descPtr;
  logic descDone, memReq, memWrite, memByte;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic memDone = 1'b0;
  logic frmValid = 1'b0, frmLast = 1'b0;
  logic [7:0] frmByte = '0;
  logic [15:0] frmLen = '0;
  logic frmReady, irqRxOk, irqRxDesc, irqRxIdle;

  always #4 clk = ~clk;

  rxd_engine dut (
    .clk(clk), .rstN(rstN), .cmdEnable(cmdEnable), .cmdDisable(cmdDisable),
    .mode64(mode64), .ptrWrEn(ptrWrEn), .ptrWrData(ptrWrData),
    .descPtr(descPtr), .descDone(descDone), .memReq(memReq),
    .memWrite(memWrite), .memByte(memByte), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memDone(memDone),
    .frmValid(frmValid), .frmByte(frmByte), .frmLast(frmLast),
    .frmLen(frmLen), .frmReady(frmReady), .irqRxOk(irqRxOk),
    .irqRxDesc(irqRxDesc), .irqRxIdle(irqRxIdle)
  );

  // memory model, logs and event counters (single writer of all of them)
  logic [7:0] mem [0:4095];
  logic pokeEn = 1'b0, fillEn = 1'b0;
  logic [31:0] pokeAddr = '0, pokeData = '0;
  int readCnt = 0, byteWrCnt = 0, wordWrCnt = 0, protoErr = 0;
  int okCnt = 0, descCnt = 0, idleCnt = 0;
  logic [31:0] rdLog [0:63];
  logic [31:0] wrLog [0:63];
  logic pending = 1'b0;
  logic [31:0] pendAddr = '0;
  int lat = 0;

  always @(negedge clk) begin
    if (fillEn) for (int i = 0; i < 4096; i++) mem[i] = 8'hEE;
    if (pokeEn) for (int k = 0; k < 4; k++) mem[pokeAddr[11:0] + 12'(k)] = pokeData[8*k +: 8];
    if (irqRxOk) okCnt++;
    if (irqRxDesc) descCnt++;
    if (irqRxIdle) idleCnt++;
    if (memDone) begin
      memDone = 1'b0;
      pending = 1'b0;
    end
    if (pending && !memReq) protoErr++;
    if (memReq) begin
      if (!pending) begin
        pending = 1'b1;
        pendAddr = memAddr;
        lat = 0;
      end else if (memAddr != pendAddr) protoErr++;
      lat++;
      if (lat >= LAT) begin
        if (!memWrite) begin
          for (int k = 0; k < 4; k++) memRdata[8*k +: 8] = mem[memAddr[11:0] + 12'(k)];
          rdLog[readCnt % 64] = memAddr;
          readCnt++;
        end else if (memByte) begin
          mem[memAddr[11:0]] = memWdata[7:0];
          byteWrCnt++;
        end else begin
          for (int k = 0; k < 4; k++) mem[memAddr[11:0] + 12'(k)] = memWdata[8*k +: 8];
          wrLog[wordWrCnt % 64] = memAddr;
          wordWrCnt++;
        end
        memDone = 1'b1;
      end
    end
  end

  int errors = 0;
  int checks = 0;
  logic finished = 1'b0;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] peek(input logic [31:0] a);
    return {mem[a[11:0] + 12'd3], mem[a[11:0] + 12'd2], mem[a[11:0] + 12'd1], mem[a[11:0]]};
  endfunction

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    pokeAddr = a; pokeData = d; pokeEn = 1'b1;
    @(negedge clk); #1;
    pokeEn = 1'b0;
  endtask

  task automatic fillMem();
    fillEn = 1'b1;
    @(negedge clk); #1;
    fillEn = 1'b0;
  endtask

  task automatic putDesc(input logic [31:0] base, input logic wide, input logic [31:0] link,
                         input logic [31:0] buff, input logic [31:0] cmd, input logic [31:0] ext);
    if (wide) begin
      poke(base, link); poke(base + 4, 32'h0);
      poke(base + 8, buff); poke(base + 12, 32'h0000_0055);
      poke(base + 16, cmd); poke(base + 20, ext);
    end else begin
      poke(base, link); poke(base + 4, buff);
      poke(base + 8, cmd); poke(base + 12, ext);
    end
  endtask

  task automatic loadPtr(input logic [31:0] p);
    @(negedge clk);
    ptrWrData = p; ptrWrEn = 1'b1;
    @(negedge clk);
    ptrWrEn = 1'b0;
  endtask

  task automatic sendFrame(input int n, input logic [7:0] seed);
    frmLen = 16'(n);
    for (int i = 0; i < n; i++) begin
      frmValid = 1'b1;
      frmByte = seed + 8'(7 * i);
      frmLast = (i == n - 1);
      while (!frmReady) @(negedge clk);
      @(negedge clk);
    end
    frmValid = 1'b0;
    frmLast = 1'b0;
  endtask

  function automatic logic [31:0] expStatus(input logic [31:0] cmd, input logic [15:0] len);
    logic [31:0] s;
    s = cmd | 32'h8000_0000 | 32'h0800_0000;
    s = s & ~32'h4000_0000;
    return {s[31:16], len};
  endfunction

  typedef struct packed {
    logic        wide;
    logic        own;
    logic        intr;
    logic        more;
    logic        flip;
    logic [15:0] budget;
    logic [15:0] flen;
  } rowT;

  localparam int NROWS = 7;
  localparam rowT ROWS [NROWS] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd16, 16'd8},
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'd32, 16'd20},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'd5,  16'd9},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd16, 16'd4},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd16, 16'd4},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'd12, 16'd12},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1,  16'd1}
  };

  task automatic runRow(input int r, input rowT v);
    logic [31:0] base, buff, cmd, ext, off;
    int sRd, sBw, sWw, sOk, sDesc, sIdle, nWr;
    logic dataOk;
    base = 32'h100 + 32'(r * 64);
    buff = 32'h800 + 32'(r * 64);
    ext  = 32'hA5A5_0000 + 32'(r);
    cmd  = {v.own, v.more, v.intr, 13'h0, v.budget};
    off  = v.wide ? 32'd16 : 32'd8;
    fillMem();
    putDesc(base, v.wide, 32'h0, buff, cmd, ext);
    loadPtr(32'hC000_0000 | base);
    sRd = readCnt; sBw = byteWrCnt; sWw = wordWrCnt;
    sOk = okCnt; sDesc = descCnt; sIdle = idleCnt;
    mode64 = v.wide;
    cmdEnable = 1'b1;
    @(negedge clk);
    cmdEnable = 1'b0;
    if (v.flip) mode64 = ~v.wide;
    if (!v.own) sendFrame(int'(v.flen), 8'(r * 16));
    for (int c = 0; c < 3000 && idleCnt == sIdle; c++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(rdLog[sRd % 64] == base, "R2 first descriptor address masked", rdLog[sRd % 64], base);
    check(readCnt - sRd == (v.wide ? 6 : 4), "R2/R11 descriptor word reads",
          32'(readCnt - sRd), v.wide ? 32'd6 : 32'd4);
    check(idleCnt - sIdle == 1, "R3/R8 idle cause once", 32'(idleCnt - sIdle), 32'd1);
    if (v.own) begin
      check(byteWrCnt == sBw && wordWrCnt == sWw, "R3 no writes on owned descriptor",
            32'(byteWrCnt - sBw + wordWrCnt - sWw), 32'd0);
      check(okCnt == sOk, "R3 no ok cause", 32'(okCnt - sOk), 32'd0);
    end else begin
      nWr = (v.flen < v.budget) ? int'(v.flen) : int'(v.budget);
      check(byteWrCnt - sBw == nWr, "R4 bytes written", 32'(byteWrCnt - sBw), 32'(nWr));
      dataOk = 1'b1;
      for (int i = 0; i < nWr; i++)
        if (mem[buff[11:0] + 12'(i)] != 8'(r * 16) + 8'(7 * i)) dataOk = 1'b0;
      check(dataOk, "R4 buffer contents", {31'h0, dataOk}, 32'd1);
      check(mem[buff[11:0] + 12'(nWr)] == 8'hEE, "R4 byte past written range untouched",
            {24'h0, mem[buff[11:0] + 12'(nWr)]}, 32'hEE);
      check(peek(base + off) == expStatus(cmd, v.flen), "R5 status word",
            peek(base + off), expStatus(cmd, v.flen));
      check(wordWrCnt - sWw == 2 && wrLog[sWw % 64] == base + off &&
            wrLog[(sWw + 1) % 64] == base + off + 4, "R6 writeback addresses",
            wrLog[sWw % 64], base + off);
      check(peek(base + off + 4) == ext, "R6 extended status unchanged", peek(base + off + 4), ext);
      check(okCnt - sOk == 1 && descCnt - sDesc == int'(v.intr), "R7 ok/desc causes",
            32'(descCnt - sDesc), {31'h0, v.intr});
    end
    check(descDone == 1'b1, "R8 chain done flag", {31'h0, descDone}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

  initial begin
    int sRd, sOk, sIdle, sDesc;
    repeat (3) @(negedge clk);
    check(!memReq && !frmReady && !descDone && descPtr == 0 && !irqRxOk && !irqRxDesc && !irqRxIdle,
          "R12 reset state", {memReq, frmReady, descDone, irqRxOk, irqRxDesc, irqRxIdle} , 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int r = 0; r < NROWS; r++) runRow(r, ROWS[r]);

    // R1: enable and disable together do not start the engine
    loadPtr(32'h100);
    sRd = readCnt;
    cmdEnable = 1'b1; cmdDisable = 1'b1;
    @(negedge clk);
    cmdEnable = 1'b0; cmdDisable = 1'b0;
    repeat (20) @(negedge clk);
    check(readCnt == sRd && !memReq, "R1 disable wins over enable", 32'(readCnt - sRd), 32'd0);

    // R8: two-descriptor chain with a link carrying high bits
    fillMem();
    mode64 = 1'b0;
    putDesc(32'h300, 1'b0, 32'h4000_0340, 32'hC00, 32'h2000_0010, 32'h1);
    putDesc(32'h340, 1'b0, 32'h0, 32'hC40, 32'h0000_0010, 32'h2);
    loadPtr(32'h300);
    sRd = readCnt; sOk = okCnt; sIdle = idleCnt; sDesc = descCnt;
    cmdEnable = 1'b1;
    @(negedge clk);
    cmdEnable = 1'b0;
    sendFrame(6, 8'h30);
    for (int c = 0; c < 3000 && okCnt == sOk; c++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(descDone == 1'b0 && idleCnt == sIdle, "R8 nonzero link continues",
          {31'h0, descDone}, 32'd0);
    sendFrame(3, 8'h60);
    for (int c = 0; c < 3000 && idleCnt == sIdle; c++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(descPtr == 32'h4000_0340, "R8 pointer follows link", descPtr, 32'h4000_0340);
    check(rdLog[(sRd + 4) % 64] == 32'h340, "R2 link address masked", rdLog[(sRd + 4) % 64], 32'h340);
    check(okCnt - sOk == 2 && descCnt - sDesc == 1 && descDone, "R7 causes over chain",
          32'(okCnt - sOk), 32'd2);
    check(peek(32'h348) == expStatus(32'h0000_0010, 16'd3), "R5 second status",
          peek(32'h348), expStatus(32'h0000_0010, 16'd3));

    // R9: disable during a frame stops after completion
    fillMem();
    putDesc(32'h380, 1'b0, 32'h3C0, 32'hD00, 32'h0000_0010, 32'h0);
    putDesc(32'h3C0, 1'b0, 32'h0, 32'hD40, 32'h0000_0010, 32'h0);
    loadPtr(32'h380);
    sRd = readCnt; sOk = okCnt; sIdle = idleCnt;
    cmdEnable = 1'b1;
    @(negedge clk);
    cmdEnable = 1'b0;
    while (!frmReady) @(negedge clk);
    cmdDisable = 1'b1;
    @(negedge clk);
    cmdDisable = 1'b0;
    sendFrame(4, 8'h90);
    for (int c = 0; c < 3000 && okCnt == sOk; c++) @(negedge clk);
    repeat (30) @(negedge clk);
    check(readCnt - sRd == 4 && idleCnt == sIdle && okCnt - sOk == 1,
          "R9 stop after completion", 32'(readCnt - sRd), 32'd4);
    check(descPtr == 32'h380 && !memReq, "R9 pointer not advanced", descPtr, 32'h380);

    check(protoErr == 0, "R10 request held until done", 32'(protoErr), 32'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule